// File: doc/BRIEF.md
# Sensorless Brushless Motor Start Sequencer

This block is the decision engine that picks how a three-phase brushless motor is brought up from whatever state it happens to be in. It idles while the speed command is zero. Once the command is non-zero it walks a fixed chain of one-clock decision states. That chain optionally looks at the motor's back-EMF comparator flags and separates three cases: standing still, turning forward, turning backward. It then ends in one of several places: a jump straight into closed-loop running, a timed coast, a timed brake, a timed stationary brake, a reverse deceleration that crosses zero speed, or plain start-up.

The measurement, commutation, ramps and speed regulation live in neighbouring blocks. The sequencer sees them only as flags, and they see the sequencer only through its state code. The block drives its six gate enables itself only during the brake, stationary-brake and coast routines. In every other state it holds all six off. All timed routines count a one-clock PWM-period strobe, `pwm_tick`, so their durations are in PWM periods.

State flow: POWER_ON → SLEEP. SLEEP → ISD_GATE when the command is non-zero. ISD_GATE → MOTION_CHK or BRK_GATE. MOTION_CHK → STAT_CHK or DIR_CHK. DIR_CHK → RESYNC_GATE or RVS_GATE. RESYNC_GATE → CLOSED_LOOP, STAT_CHK or HIZ_GATE. STAT_CHK → SBRK_GATE or COAST. COAST → SBRK_GATE. SBRK_GATE → SBRK_RUN or STARTUP. SBRK_RUN → STARTUP. RVS_GATE → RVS_CL_DECEL or HIZ_GATE. RVS_CL_DECEL → RVS_OL_DECEL → FWD_OL_ACCEL. HIZ_GATE → HIZ_RUN or BRK_GATE. HIZ_RUN → BRK_GATE. BRK_GATE → BRK_RUN or STARTUP. BRK_RUN → STARTUP. STARTUP, CLOSED_LOOP and FWD_OL_ACCEL are end states. From any state, a zero command returns the block to SLEEP.

Top module: `mss_start_seq`

## Requirements
- R1: While `rst` is high the state code is 0 (POWER_ON) and all gates are off; the first clock after release moves to state 1 (SLEEP).
- R2: SLEEP (1) holds while `cmd` is zero; a non-zero `cmd` moves it to ISD_GATE (2) on the next clock. Each decision state lasts exactly one clock.
- R3: Whenever `cmd` is zero at a clock edge, in any state, the next state is SLEEP (1), and `gate_o` is 000000 in SLEEP.
- R4: ISD_GATE goes to BRK_GATE (16) when `cfg_isd_en` is 0, otherwise to MOTION_CHK (3). MOTION_CHK goes to STAT_CHK (6) if `bemf_lt_stat` is 1, else to DIR_CHK (4).
- R5: DIR_CHK goes to RVS_GATE (10) if `dir_rev` is 1, else to RESYNC_GATE (5).
- R6: RESYNC_GATE goes to CLOSED_LOOP (19) when `cfg_resync_en` and `bemf_gt_resync` are both 1. With resync enabled and `bemf_gt_resync` 0 it goes to STAT_CHK (6). With resync disabled it goes to HIZ_GATE (14).
- R7: STAT_CHK goes to SBRK_GATE (8) if `bemf_lt_stat` is 1, else to COAST (7). COAST leaves for SBRK_GATE on the first clock that `bemf_lt_stat` is 1.
- R8: COAST also leaves for SBRK_GATE on exactly the COAST_CYCLES-th `pwm_tick` after entry, whatever the back-EMF flag says.
- R9: SBRK_GATE goes to SBRK_RUN (9) if `cfg_sbrk_en` is 1, else to STARTUP (18). SBRK_RUN drives `gate_o` = 010101 (all low sides on), then goes to STARTUP.
- R10: RVS_GATE goes to RVS_CL_DECEL (11) if `cfg_rvs_en` is 1, else to HIZ_GATE (14). RVS_CL_DECEL stays while `rvs_above_min` is 1, then goes to RVS_OL_DECEL (12). That state stays until `rvs_zero` is 1, then goes to FWD_OL_ACCEL (13).
- R11: HIZ_GATE goes to HIZ_RUN (15) if `cfg_hiz_en` is 1, else to BRK_GATE (16). HIZ_RUN holds `gate_o` = 000000 and then goes to BRK_GATE.
- R12: BRK_GATE goes to BRK_RUN (17) if `cfg_brk_en` is 1, else to STARTUP (18). BRK_RUN drives 101010 (all high sides) when `cfg_brk_hs` is 1 and 010101 (all low sides) when it is 0, then goes to STARTUP.
- R13: A timed routine with programmed count N leaves on its (N+1)-th `pwm_tick`, so a count of zero leaves after a single strobe.
- R14: `gate_o` is ordered {AH,AL,BH,BL,CH,CL}, and no phase ever has its high and low bit set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd | input | CMD_W | Speed/power/duty command; zero means stop |
| pwm_tick | input | 1 | One-clock strobe per PWM period |
| cfg_isd_en | input | 1 | Enable the initial motion check |
| cfg_resync_en | input | 1 | Enable jump into closed loop on forward spin |
| cfg_rvs_en | input | 1 | Enable reverse-drive deceleration |
| cfg_hiz_en | input | 1 | Enable timed coast routine |
| cfg_brk_en | input | 1 | Enable timed brake routine |
| cfg_brk_hs | input | 1 | Brake on high sides (1) or low sides (0) |
| cfg_sbrk_en | input | 1 | Enable stationary brake routine |
| cfg_hiz_time | input | TIME_W | Hi-Z routine count |
| cfg_brk_time | input | TIME_W | Brake routine count |
| cfg_sbrk_time | input | TIME_W | Stationary brake routine count |
| bemf_lt_stat | input | 1 | Back-EMF below stationary threshold |
| bemf_gt_resync | input | 1 | Back-EMF above resync minimum threshold |
| dir_rev | input | 1 | Detected spin is reverse |
| rvs_above_min | input | 1 | Reverse speed above minimum-duty speed |
| rvs_zero | input | 1 | Reverse deceleration has reached zero speed |
| gate_o | output | 6 | Gate enables {AH,AL,BH,BL,CH,CL} |
| state_o | output | 5 | Current state code |

## Verification
The hardest situation to reach is the coast timeout. It needs a motor that looks neither stationary nor fast enough to resynchronise, and that condition must hold through many PWM periods. The bench builds a small copy of the block with COAST_CYCLES set to 10 and routes it through a forward spin with resync enabled and `bemf_gt_resync` low. It then counts strobes one by one, checking that the block stays in COAST after the ninth and leaves on the tenth. The early exit is reached the same way: the bench raises the stationary flag part way through the wait.

// File: rtl/mss_pkg.sv
package mss_pkg;

    typedef enum logic [4:0] {
        ST_POWER_ON     = 5'd0,
        ST_SLEEP        = 5'd1,
        ST_ISD_GATE     = 5'd2,
        ST_MOTION_CHK   = 5'd3,
        ST_DIR_CHK      = 5'd4,
        ST_RESYNC_GATE  = 5'd5,
        ST_STAT_CHK     = 5'd6,
        ST_COAST        = 5'd7,
        ST_SBRK_GATE    = 5'd8,
        ST_SBRK_RUN     = 5'd9,
        ST_RVS_GATE     = 5'd10,
        ST_RVS_CL_DECEL = 5'd11,
        ST_RVS_OL_DECEL = 5'd12,
        ST_FWD_OL_ACCEL = 5'd13,
        ST_HIZ_GATE     = 5'd14,
        ST_HIZ_RUN      = 5'd15,
        ST_BRK_GATE     = 5'd16,
        ST_BRK_RUN      = 5'd17,
        ST_STARTUP      = 5'd18,
        ST_CLOSED_LOOP  = 5'd19
    } mss_state_e;

    localparam int unsigned N_PHASE = 3;
    localparam int unsigned GATE_W  = 2 * N_PHASE;

endpackage

// File: rtl/mss_cycle_timer.sv
module mss_cycle_timer #(
    parameter int unsigned CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;

    // Counter is held at zero outside a timed routine, so every
    // routine starts counting from its first strobe.
    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign done = run && tick && (cnt_q == limit);

endmodule

// File: rtl/mss_gate_map.sv
module mss_gate_map #(
    parameter int unsigned N_PH = 3
) (
    input  logic            drive_lo,
    input  logic            drive_hi,
    output logic [2*N_PH-1:0] gates
);

    logic hi_ok;
    logic lo_ok;

    // Low-side request wins; the two sides of a phase are exclusive.
    always_comb begin
        lo_ok = drive_lo;
        hi_ok = drive_hi && !drive_lo;
    end

    // Bit 2p+1 is the high side and bit 2p the low side of phase p,
    // counted from the least significant pair (phase C).
    for (genvar p = 0; p < N_PH; p++) begin : g_phase
        assign gates[2*p+1] = hi_ok;
        assign gates[2*p]   = lo_ok;
    end

endmodule

// File: rtl/mss_start_seq.sv
module mss_start_seq
    import mss_pkg::*;
#(
    parameter int unsigned CMD_W        = 16,
    parameter int unsigned TIME_W       = 20,
    parameter int unsigned COAST_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              pwm_tick,
    input  logic              cfg_isd_en,
    input  logic              cfg_resync_en,
    input  logic              cfg_rvs_en,
    input  logic              cfg_hiz_en,
    input  logic              cfg_brk_en,
    input  logic              cfg_brk_hs,
    input  logic              cfg_sbrk_en,
    input  logic [TIME_W-1:0] cfg_hiz_time,
    input  logic [TIME_W-1:0] cfg_brk_time,
    input  logic [TIME_W-1:0] cfg_sbrk_time,
    input  logic              bemf_lt_stat,
    input  logic              bemf_gt_resync,
    input  logic              dir_rev,
    input  logic              rvs_above_min,
    input  logic              rvs_zero,
    output logic [5:0]        gate_o,
    output logic [4:0]        state_o
);

    localparam int unsigned COAST_W = $clog2(COAST_CYCLES + 1);
    localparam int unsigned CNT_W   = (TIME_W > COAST_W) ? TIME_W : COAST_W;
    localparam logic [CNT_W-1:0] COAST_LIM = CNT_W'(COAST_CYCLES - 1);

    mss_state_e       state_q;
    mss_state_e       state_d;
    logic             cmd_zero;
    logic             tmr_run;
    logic             tmr_done;
    logic [CNT_W-1:0] tmr_limit;
    logic             drv_lo;
    logic             drv_hi;
    logic [GATE_W-1:0] gates_w;

    assign cmd_zero = (cmd == '0);

    // ---------------- shared routine timer ----------------
    always_comb begin
        tmr_run   = 1'b0;
        tmr_limit = '0;
        unique case (state_q)
            ST_COAST: begin
                tmr_run   = 1'b1;
                tmr_limit = COAST_LIM;
            end
            ST_SBRK_RUN: begin
                tmr_run   = 1'b1;
                tmr_limit = CNT_W'(cfg_sbrk_time);
            end
            ST_HIZ_RUN: begin
                tmr_run   = 1'b1;
                tmr_limit = CNT_W'(cfg_hiz_time);
            end
            ST_BRK_RUN: begin
                tmr_run   = 1'b1;
                tmr_limit = CNT_W'(cfg_brk_time);
            end
            default: begin
                tmr_run   = 1'b0;
                tmr_limit = '0;
            end
        endcase
    end

    mss_cycle_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run   (tmr_run),
        .tick  (pwm_tick),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    // ---------------- next-state decisions ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_POWER_ON:     state_d = ST_SLEEP;
            ST_SLEEP:        state_d = cmd_zero ? ST_SLEEP : ST_ISD_GATE;
            ST_ISD_GATE:     state_d = cfg_isd_en ? ST_MOTION_CHK : ST_BRK_GATE;
            ST_MOTION_CHK:   state_d = bemf_lt_stat ? ST_STAT_CHK : ST_DIR_CHK;
            ST_DIR_CHK:      state_d = dir_rev ? ST_RVS_GATE : ST_RESYNC_GATE;
            ST_RESYNC_GATE: begin
                if (!cfg_resync_en)      state_d = ST_HIZ_GATE;
                else if (bemf_gt_resync) state_d = ST_CLOSED_LOOP;
                else                     state_d = ST_STAT_CHK;
            end
            ST_STAT_CHK:     state_d = bemf_lt_stat ? ST_SBRK_GATE : ST_COAST;
            ST_COAST: begin
                if (bemf_lt_stat || tmr_done) state_d = ST_SBRK_GATE;
            end
            ST_SBRK_GATE:    state_d = cfg_sbrk_en ? ST_SBRK_RUN : ST_STARTUP;
            ST_SBRK_RUN: begin
                if (tmr_done) state_d = ST_STARTUP;
            end
            ST_RVS_GATE:     state_d = cfg_rvs_en ? ST_RVS_CL_DECEL : ST_HIZ_GATE;
            ST_RVS_CL_DECEL: begin
                if (!rvs_above_min) state_d = ST_RVS_OL_DECEL;
            end
            ST_RVS_OL_DECEL: begin
                if (rvs_zero) state_d = ST_FWD_OL_ACCEL;
            end
            ST_FWD_OL_ACCEL: state_d = ST_FWD_OL_ACCEL;
            ST_HIZ_GATE:     state_d = cfg_hiz_en ? ST_HIZ_RUN : ST_BRK_GATE;
            ST_HIZ_RUN: begin
                if (tmr_done) state_d = ST_BRK_GATE;
            end
            ST_BRK_GATE:     state_d = cfg_brk_en ? ST_BRK_RUN : ST_STARTUP;
            ST_BRK_RUN: begin
                if (tmr_done) state_d = ST_STARTUP;
            end
            ST_STARTUP:      state_d = ST_STARTUP;
            ST_CLOSED_LOOP:  state_d = ST_CLOSED_LOOP;
            default:         state_d = ST_SLEEP;
        endcase
        // A zero command overrides every decision except leaving power-on,
        // whose only exit is sleep anyway.
        if (cmd_zero) state_d = ST_SLEEP;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_POWER_ON;
        end else begin
            state_q <= state_d;
        end
    end

    // ---------------- outputs ----------------
    always_comb begin
        drv_lo = 1'b0;
        drv_hi = 1'b0;
        unique case (state_q)
            ST_SBRK_RUN: drv_lo = 1'b1;
            ST_BRK_RUN: begin
                drv_hi = cfg_brk_hs;
                drv_lo = !cfg_brk_hs;
            end
            default: begin
                drv_lo = 1'b0;
                drv_hi = 1'b0;
            end
        endcase
    end

    mss_gate_map #(
        .N_PH (N_PHASE)
    ) u_gates (
        .drive_lo (drv_lo),
        .drive_hi (drv_hi),
        .gates    (gates_w)
    );

    assign gate_o  = gates_w;
    assign state_o = state_q;

endmodule

// File: rtl/mss_start_seq_chk.sv
module mss_start_seq_chk
    import mss_pkg::*;
#(
    parameter int unsigned CMD_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CMD_W-1:0] cmd,
    input logic             cfg_isd_en,
    input logic             cfg_resync_en,
    input logic             bemf_gt_resync,
    input logic             dir_rev,
    input logic [5:0]       gate_o,
    input logic [4:0]       state_o
);

    logic nz;
    assign nz = (cmd != '0);

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (state_o == ST_POWER_ON)); // R1

    AST_PWRON_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_POWER_ON) |=> (state_o == ST_SLEEP)); // R1

    AST_SLEEP_EXIT: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_SLEEP && nz) |=> (state_o == ST_ISD_GATE)); // R2

    AST_ZERO_CMD_SLEEP: assert property (@(posedge clk) disable iff (rst)
        (!nz) |=> (state_o == ST_SLEEP)); // R3

    AST_SLEEP_GATES_OFF: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_SLEEP) |-> (gate_o == 6'b000000)); // R3

    AST_ISD_SKIP: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_ISD_GATE && !cfg_isd_en && nz) |=> (state_o == ST_BRK_GATE)); // R4

    AST_DIR_SPLIT: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_DIR_CHK && dir_rev && nz) |=> (state_o == ST_RVS_GATE)); // R5

    AST_RESYNC_JUMP: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_RESYNC_GATE && cfg_resync_en && bemf_gt_resync && nz)
        |=> (state_o == ST_CLOSED_LOOP)); // R6

    AST_BRAKE_THREE_ON: assert property (@(posedge clk) disable iff (rst)
        (state_o == ST_BRK_RUN || state_o == ST_SBRK_RUN) |-> ($countones(gate_o) == 3)); // R12

    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst)
        !((gate_o[5] && gate_o[4]) || (gate_o[3] && gate_o[2]) || (gate_o[1] && gate_o[0]))); // R14

endmodule

bind mss_start_seq mss_start_seq_chk #(
    .CMD_W (CMD_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd            (cmd),
    .cfg_isd_en     (cfg_isd_en),
    .cfg_resync_en  (cfg_resync_en),
    .bemf_gt_resync (bemf_gt_resync),
    .dir_rev        (dir_rev),
    .gate_o         (gate_o),
    .state_o        (state_o)
);

// File: tb/tb_mss_start_seq.sv
module tb_mss_start_seq;

    localparam int CMD_W  = 16;
    localparam int TIME_W = 20;
    localparam int COAST  = 10;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [CMD_W-1:0]  cmd = '0;
    logic              pwm_tick = 1'b0;
    logic              cfg_isd_en = 1'b0, cfg_resync_en = 1'b0, cfg_rvs_en = 1'b0;
    logic              cfg_hiz_en = 1'b0, cfg_brk_en = 1'b0, cfg_brk_hs = 1'b0;
    logic              cfg_sbrk_en = 1'b0;
    logic [TIME_W-1:0] cfg_hiz_time = 20'd5, cfg_brk_time = 20'd5, cfg_sbrk_time = 20'd5;
    logic              bemf_lt_stat = 1'b0, bemf_gt_resync = 1'b0, dir_rev = 1'b0;
    logic              rvs_above_min = 1'b0, rvs_zero = 1'b0;
    logic [5:0]        gate_o;
    logic [4:0]        state_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    mss_start_seq #(
        .CMD_W (CMD_W), .TIME_W (TIME_W), .COAST_CYCLES (COAST)
    ) dut (
        .clk (clk), .rst (rst), .cmd (cmd), .pwm_tick (pwm_tick),
        .cfg_isd_en (cfg_isd_en), .cfg_resync_en (cfg_resync_en),
        .cfg_rvs_en (cfg_rvs_en), .cfg_hiz_en (cfg_hiz_en),
        .cfg_brk_en (cfg_brk_en), .cfg_brk_hs (cfg_brk_hs),
        .cfg_sbrk_en (cfg_sbrk_en), .cfg_hiz_time (cfg_hiz_time),
        .cfg_brk_time (cfg_brk_time), .cfg_sbrk_time (cfg_sbrk_time),
        .bemf_lt_stat (bemf_lt_stat), .bemf_gt_resync (bemf_gt_resync),
        .dir_rev (dir_rev), .rvs_above_min (rvs_above_min),
        .rvs_zero (rvs_zero), .gate_o (gate_o), .state_o (state_o)
    );

    // Vector: cfg {isd,resync,rvs,hiz,brk,brk_hs,sbrk}, flags
    // {lt_stat,gt_resync,rev,above_min,zero}, expected state, expected gates.
    localparam int NV = 13;
    localparam logic [22:0] VEC [NV] = '{
        {7'b0000000, 5'b00000, 5'd18, 6'b000000},
        {7'b0000100, 5'b00000, 5'd17, 6'b010101},
        {7'b0000110, 5'b00000, 5'd17, 6'b101010},
        {7'b1000000, 5'b10000, 5'd18, 6'b000000},
        {7'b1000001, 5'b10000, 5'd9,  6'b010101},
        {7'b1100000, 5'b01000, 5'd19, 6'b000000},
        {7'b1100000, 5'b00000, 5'd7,  6'b000000},
        {7'b1001000, 5'b00000, 5'd15, 6'b000000},
        {7'b1000000, 5'b00000, 5'd18, 6'b000000},
        {7'b1010000, 5'b00110, 5'd11, 6'b000000},
        {7'b1010000, 5'b00100, 5'd12, 6'b000000},
        {7'b1010000, 5'b00101, 5'd13, 6'b000000},
        {7'b1000100, 5'b00100, 5'd17, 6'b010101}
    };

    function automatic string vec_tag(int i);
        case (i)
            0:  return "R4 R12";
            1:  return "R12";
            2:  return "R12 R14";
            3:  return "R4 R7 R9";
            4:  return "R9";
            5:  return "R5 R6";
            6:  return "R6 R7";
            7:  return "R6 R11";
            8:  return "R11 R12";
            9:  return "R10";
            10: return "R10";
            11: return "R10";
            default: return "R5 R10 R11";
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic restart();
        @(negedge clk);
        rst = 1'b1; cmd = '0; pwm_tick = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic go_and_wait(int n);
        cmd = 16'd5;
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(int n);
        for (int k = 0; k < n; k++) begin
            pwm_tick = 1'b1;
            @(negedge clk);
            pwm_tick = 1'b0;
            @(negedge clk);
        end
    endtask

    task automatic clear_cfg();
        {cfg_isd_en, cfg_resync_en, cfg_rvs_en, cfg_hiz_en,
         cfg_brk_en, cfg_brk_hs, cfg_sbrk_en} = 7'b0;
        {bemf_lt_stat, bemf_gt_resync, dir_rev, rvs_above_min, rvs_zero} = 5'b0;
        cfg_hiz_time = 20'd5; cfg_brk_time = 20'd5; cfg_sbrk_time = 20'd5;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // ---- reset behaviour ----
        @(negedge clk); @(negedge clk);
        chk("R1 reset state", 32'(state_o), 32'd0);
        chk("R1 reset gates", 32'(gate_o), 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 leave power-on", 32'(state_o), 32'd1);
        repeat (5) @(negedge clk);
        chk("R2 hold sleep", 32'(state_o), 32'd1);
        cmd = 16'd1;
        @(negedge clk);
        chk("R2 exit sleep", 32'(state_o), 32'd2);

        // ---- table of paths ----
        for (int i = 0; i < NV; i++) begin
            restart();
            {cfg_isd_en, cfg_resync_en, cfg_rvs_en, cfg_hiz_en,
             cfg_brk_en, cfg_brk_hs, cfg_sbrk_en} = VEC[i][22:16];
            {bemf_lt_stat, bemf_gt_resync, dir_rev, rvs_above_min, rvs_zero} = VEC[i][15:11];
            go_and_wait(12);
            chk({vec_tag(i), " path state"}, 32'(state_o), 32'(VEC[i][10:6]));
            chk({vec_tag(i), " path gates"}, 32'(gate_o), 32'(VEC[i][5:0]));
        end

        // ---- R3: command drop from a brake ----
        clear_cfg();
        restart();
        cfg_brk_en = 1'b1; cfg_brk_hs = 1'b1;
        go_and_wait(6);
        chk("R12 high brake", 32'(gate_o), 32'h2a);
        cmd = '0;
        @(negedge clk);
        chk("R3 drop to sleep", 32'(state_o), 32'd1);
        chk("R3 gates off", 32'(gate_o), 32'd0);

        // ---- R11/R13: Hi-Z count of 3 ----
        clear_cfg();
        restart();
        cfg_isd_en = 1'b1; cfg_hiz_en = 1'b1; cfg_hiz_time = 20'd3;
        go_and_wait(10);
        chk("R11 in hi-z", 32'(state_o), 32'd15);
        ticks(3);
        chk("R13 hi-z after 3 strobes", 32'(state_o), 32'd15);
        ticks(1);
        chk("R11 hi-z to brake gate", 32'(state_o), 32'd18);

        // ---- R13: zero count ----
        clear_cfg();
        restart();
        cfg_brk_en = 1'b1; cfg_brk_time = 20'd0;
        go_and_wait(6);
        chk("R13 brake entered", 32'(state_o), 32'd17);
        ticks(1);
        chk("R13 zero count single strobe", 32'(state_o), 32'd18);

        // ---- R8: coast timeout, then R9 stationary brake ----
        clear_cfg();
        restart();
        cfg_isd_en = 1'b1; cfg_resync_en = 1'b1;
        cfg_sbrk_en = 1'b1; cfg_sbrk_time = 20'd2;
        go_and_wait(10);
        chk("R7 in coast", 32'(state_o), 32'd7);
        ticks(COAST - 1);
        chk("R8 coast before limit", 32'(state_o), 32'd7);
        pwm_tick = 1'b1;
        @(negedge clk);
        pwm_tick = 1'b0;
        chk("R8 coast timeout", 32'(state_o), 32'd8);
        @(negedge clk);
        chk("R9 stationary brake", 32'(state_o), 32'd9);
        chk("R9 low-side gates", 32'(gate_o), 32'h15);
        ticks(2);
        chk("R13 stationary brake holds", 32'(state_o), 32'd9);
        ticks(1);
        chk("R9 to startup", 32'(state_o), 32'd18);

        // ---- R7: early coast exit ----
        clear_cfg();
        restart();
        cfg_isd_en = 1'b1; cfg_resync_en = 1'b1;
        cfg_sbrk_en = 1'b1;
        go_and_wait(10);
        ticks(4);
        bemf_lt_stat = 1'b1;
        @(negedge clk);
        chk("R7 early coast exit", 32'(state_o), 32'd8);

        // ---- R10: reverse through zero, live flag changes ----
        clear_cfg();
        restart();
        cfg_isd_en = 1'b1; cfg_rvs_en = 1'b1; dir_rev = 1'b1; rvs_above_min = 1'b1;
        go_and_wait(8);
        chk("R10 closed-loop decel", 32'(state_o), 32'd11);
        rvs_above_min = 1'b0;
        @(negedge clk);
        chk("R10 open-loop decel", 32'(state_o), 32'd12);
        rvs_zero = 1'b1;
        @(negedge clk);
        chk("R10 forward accel", 32'(state_o), 32'd13);
        chk("R14 drive states gates off", 32'(gate_o), 32'd0);

        finish_run();
    end

endmodule